// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block turns a set of slow control pins into the 4-bit switch word for a binary-weighted step attenuator. It also reports the total attenuation in dB. A mode input chooses between two control paths.

In serial mode a three-wire link loads an 8-stage shift register. The link carries a data line, a shift clock and a strobe. The last stage of the register drives a daisy-chain output, so several devices can share one serial link. In parallel mode four pins set the word. They either reach the output directly, or they are captured by the strobe.

The strobe has more than one job. In serial mode a high level copies the shift register to the switch word and blocks the shift clock. In parallel mode a high level makes the path transparent and a low level holds the word. All pins are asynchronous to the system clock. They pass through one two-flop synchronizer, so data and clocks stay aligned, and the shift clock is edge-detected in the system clock domain.

Four named states, set by the synchronized mode and strobe, govern the control word:

- SER_SHIFT: serial mode, strobe low. Shifting is allowed and the word holds.
- SER_XFER: serial mode, strobe high. The shift register is copied to the word and shifting is masked.
- PAR_HOLD: parallel mode, strobe low. The word holds.
- PAR_PASS: parallel mode, strobe high. The word follows the parallel pins.

The transitions between them are:

- The strobe rising moves SER_SHIFT to SER_XFER and PAR_HOLD to PAR_PASS.
- The strobe falling takes the reverse paths.
- The mode falling moves either serial state to the parallel state with the same strobe level.
- The mode rising moves either parallel state to the serial state with the same strobe level.

Top module: `step_atten_ctrl`

## Requirements
- R1: With `ser_mode` high the word is set only from the serial path, and the parallel pins have no effect. With `ser_mode` low the word is set only from the parallel pins, and shift clock edges do not change the shift register.
- R2: In serial mode with the strobe low, each rising edge of `sh_clk` shifts `sh_data` into stage 0 and moves every stage up by one. The word is therefore sent most significant bit first.
- R3: While the strobe is high, rising edges of `sh_clk` are ignored, and the shift register and `chain_out` hold their values.
- R4: In serial mode a high strobe copies shift stages 5..2 to `atten_word[3:0]`. Stage 5 goes to bit 3.
- R5: For an 8-bit word the switch bits are the third to sixth bits sent, and the first two and last two bits have no effect. A 6-bit word sets the switch bits from its first four bits.
- R6: `chain_out` is stage 7 of the shift register. A bit sent on `sh_data` therefore appears on `chain_out` after the eighth accepted shift clock edge, counting from the one that took it in.
- R7: In parallel mode with the strobe held high, `atten_word` follows `par_bits` continuously.
- R8: In parallel mode with the strobe low, `atten_word` holds the value captured while the strobe was last high, whatever `par_bits` does.
- R9: `atten_dbs` equals the sum of the weights of the set word bits: bit 3 is 16 dB, bit 2 is 8 dB, bit 1 is 4 dB and bit 0 is 2 dB. The range is 0 to 30 dB in 2 dB steps.
- R10: After reset the shift register and `atten_word` are zero, `atten_dbs` is 0 and `chain_out` is low.
- R11: `chain_out` keeps its value when the mode changes to parallel, and while parallel control is in use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ser_mode | input | 1 | 1 = serial control, 0 = parallel control |
| strobe | input | 1 | Transfer strobe, shift mask and transparency select |
| sh_clk | input | 1 | Serial shift clock, asynchronous |
| sh_data | input | 1 | Serial data in, sent MSB first |
| par_bits | input | 4 | Parallel switch bits, bit 3 = 16 dB |
| atten_word | output | 4 | Switch control word, bit 3 = 16 dB |
| atten_dbs | output | 5 | Total attenuation in dB |
| chain_out | output | 1 | Daisy-chain serial output |

## Verification
The assertions assume that every input is held stable for at least four system clocks around any change of `sh_clk` or `strobe`:

- `sh_data` is stable across each rising shift edge.
- `par_bits` is stable across each strobe edge.
- `sh_clk` is low when reset is released.

The stimulus meets these assumptions by construction:

- Each serial bit spends eight system clocks in a shift clock period.
- Data changes only when the shift clock falls.
- Every strobe pulse lasts eight clocks.
- Changes to `par_bits` are separated from strobe edges by a settle time.

The random mix covers mode, strobe level, word length and data values, and also shift clocks sent while shifting is masked.

// File: rtl/atten_pkg.sv
package atten_pkg;

    typedef enum logic [1:0] {
        ST_SER_SHIFT = 2'd0,
        ST_SER_XFER  = 2'd1,
        ST_PAR_HOLD  = 2'd2,
        ST_PAR_PASS  = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/atten_shifter.sv
module atten_shifter #(
    parameter int DEPTH   = 8,
    parameter int FLD_LSB = 2,
    parameter int FLD_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [FLD_W-1:0] field,
    output logic             sdout
);
    logic [DEPTH-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[DEPTH-2:0], din};
    end

    assign field = sr_q[FLD_LSB +: FLD_W];
    assign sdout = sr_q[DEPTH-1];

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sr_q));

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sr_q[0] == $past(din));

    assert_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sdout == $past(sr_q[DEPTH-2]));

endmodule

// File: rtl/atten_ctl_fsm.sv
module atten_ctl_fsm
    import atten_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_s,
    input  logic          le_s,
    input  logic          sclk_s,
    input  logic [CW-1:0] ser_field,
    input  logic [CW-1:0] par_s,
    output logic          shift_en,
    output logic [CW-1:0] ctrl
);
    ctl_state_e state_q, state_d;
    logic       sclk_q;
    logic       sclk_rise;
    logic [CW-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end
    assign sclk_rise = sclk_s & ~sclk_q;

    always_comb begin
        unique case ({mode_s, le_s})
            2'b10:   state_d = ST_SER_SHIFT;
            2'b11:   state_d = ST_SER_XFER;
            2'b00:   state_d = ST_PAR_HOLD;
            default: state_d = ST_PAR_PASS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SER_SHIFT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            unique case (state_q)
                ST_SER_XFER: ctrl_q <= ser_field;
                ST_PAR_PASS: ctrl_q <= par_s;
                default:     ctrl_q <= ctrl_q;
            endcase
        end
    end

    assign shift_en = (state_q == ST_SER_SHIFT) && sclk_rise;
    assign ctrl     = ctrl_q;

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAR_HOLD) |=> $stable(ctrl_q));

    assert_serhold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SER_SHIFT) |=> $stable(ctrl_q));

    assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAR_PASS) |=> ctrl_q == $past(par_s));

    assert_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SER_XFER) |=> ctrl_q == $past(ser_field));

endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
    parameter int CTRL_W      = 4,
    parameter int SHIFT_DEPTH = 8,
    parameter int CTRL_LSB    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int STEP_DB     = 2,
    localparam int MAX_DB     = STEP_DB * ((1 << CTRL_W) - 1),
    localparam int DB_W       = $clog2(MAX_DB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_mode,
    input  logic              strobe,
    input  logic              sh_clk,
    input  logic              sh_data,
    input  logic [CTRL_W-1:0] par_bits,
    output logic [CTRL_W-1:0] atten_word,
    output logic [DB_W-1:0]   atten_dbs,
    output logic              chain_out
);
    localparam int SYNC_W = 4 + CTRL_W;

    logic [SYNC_W-1:0] raw_bus, sync_bus;
    logic              mode_s, le_s, sclk_s, sdata_s;
    logic [CTRL_W-1:0] par_s, ser_field;
    logic              shift_en;
    logic [DB_W-1:0]   weight_term [CTRL_W];

    assign raw_bus = {ser_mode, strobe, sh_clk, sh_data, par_bits};

    atten_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_bus),
        .sync_out (sync_bus)
    );

    assign {mode_s, le_s, sclk_s, sdata_s, par_s} = sync_bus;

    atten_shifter #(.DEPTH(SHIFT_DEPTH), .FLD_LSB(CTRL_LSB), .FLD_W(CTRL_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (sdata_s),
        .field    (ser_field),
        .sdout    (chain_out)
    );

    atten_ctl_fsm #(.CW(CTRL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_s    (mode_s),
        .le_s      (le_s),
        .sclk_s    (sclk_s),
        .ser_field (ser_field),
        .par_s     (par_s),
        .shift_en  (shift_en),
        .ctrl      (atten_word)
    );

    generate
        for (genvar i = 0; i < CTRL_W; i++) begin : g_weight
            assign weight_term[i] = atten_word[i] ? DB_W'(STEP_DB << i) : '0;
        end
    endgenerate

    always_comb begin
        atten_dbs = '0;
        for (int i = 0; i < CTRL_W; i++) atten_dbs = atten_dbs + weight_term[i];
    end

    assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (atten_dbs <= DB_W'(MAX_DB)) && ((atten_dbs % DB_W'(STEP_DB)) == '0));

    assert_parquiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_s && !$past(!mode_s ? 1'b0 : 1'b1)) |-> $stable(chain_out));

endmodule

// File: tb/step_atten_ctrl_bench.sv
`timescale 1ns/1ps
module step_atten_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_mode = 1'b1;
    logic       strobe = 1'b0;
    logic       sh_clk = 1'b0;
    logic       sh_data = 1'b0;
    logic [3:0] par_bits = 4'd0;
    logic [3:0] atten_word;
    logic [4:0] atten_dbs;
    logic       chain_out;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    logic [7:0] mdl = 8'd0;
    logic [3:0] exp_word = 4'd0;

    always #2 clk = ~clk;

    step_atten_ctrl u_step_atten_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_mode   (ser_mode),
        .strobe     (strobe),
        .sh_clk     (sh_clk),
        .sh_data    (sh_data),
        .par_bits   (par_bits),
        .atten_word (atten_word),
        .atten_dbs  (atten_dbs),
        .chain_out  (chain_out)
    );

    function automatic int db_of(input logic [3:0] w);
        int s = 0;
        for (int i = 0; i < 4; i++) if (w[i]) s += 2 << i;
        return s;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int got, input int expv);
        n_cmp++;
        if (got != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, expv);
        end
    endtask

    task automatic settle();
        tick(8);
        if (strobe) exp_word = ser_mode ? mdl[5:2] : par_bits;
    endtask

    task automatic check_out(input string tag);
        chk({tag, " word"}, atten_word, exp_word);
        chk({tag, " R9 dB"}, atten_dbs, db_of(exp_word));
    endtask

    task automatic shift_bit(input logic b, input bit chk_chain);
        sh_data = b;
        sh_clk  = 1'b0;
        tick(4);
        sh_clk = 1'b1;
        tick(4);
        if (ser_mode && !strobe) mdl = {mdl[6:0], b};
        if (chk_chain) chk("R6 chain_out", chain_out, mdl[7]);
    endtask

    task automatic send_word(input logic [7:0] v, input int nbits, input bit chk_chain);
        for (int i = nbits - 1; i >= 0; i--) shift_bit(v[i], chk_chain);
        sh_clk = 1'b0;
        tick(4);
    endtask

    task automatic pulse();
        strobe = 1'b1;
        settle();
        strobe = 1'b0;
        settle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] held;
        logic       chain_keep;
        void'($urandom(32'd20240611));
        tick(5);
        // R10 reset state
        chk("R10 word", atten_word, 0);
        chk("R10 dB", atten_dbs, 0);
        chk("R10 chain_out", chain_out, 0);
        rst_n = 1'b1;
        tick(4);
        chk("R10 word after release", atten_word, 0);

        // R2 R4 R5: full 8-bit word, D7..D0 = 1011_0110 -> word 1101
        ser_mode = 1'b1;
        send_word(8'b1011_0110, 8, 1'b1);
        chk("R3 word before strobe", atten_word, 0);
        pulse();
        check_out("R4 serial transfer");
        chk("R5 8-bit field", atten_word, 4'b1101);

        // R9 corner: all ones -> 30 dB
        send_word(8'hFF, 8, 1'b1);
        pulse();
        check_out("R9 max");
        chk("R9 30 dB", atten_dbs, 30);

        // R5: 6-bit word D5..D0 = 0110_11 -> word 0110
        send_word(8'b0001_1011, 6, 1'b0);
        pulse();
        check_out("R5 six-bit");
        chk("R5 six-bit field", atten_word, 4'b0110);

        // R5: outer bits ignored: 11_0000_11 -> 0 dB
        send_word(8'b1100_0011, 8, 1'b0);
        pulse();
        chk("R5 outer ignored", atten_word, 0);
        chk("R9 0 dB", atten_dbs, 0);

        // R3: shift clocks while strobe high are masked
        send_word(8'b0010_1000, 8, 1'b0);
        strobe = 1'b1;
        settle();
        chain_keep = chain_out;
        send_word(8'hD7, 8, 1'b0);
        chk("R3 chain_out hold", chain_out, chain_keep);
        chk("R3 word hold", atten_word, 4'b1010);
        strobe = 1'b0;
        settle();
        pulse();
        chk("R3 masked shift", atten_word, 4'b1010);

        // R1: parallel pins ignored in serial mode
        par_bits = 4'b0101;
        settle();
        pulse();
        chk("R1 par ignored serial", atten_word, 4'b1010);

        // R11 and R1: parallel mode, chain_out kept, shift ignored
        chain_keep = chain_out;
        ser_mode = 1'b0;
        settle();
        chk("R11 chain_out on mode change", chain_out, chain_keep);
        send_word(8'h5A, 8, 1'b0);
        chk("R11 chain_out in parallel", chain_out, chain_keep);
        chk("R1 serial ignored parallel", atten_word, 4'b1010);

        // R7 direct parallel
        strobe = 1'b1;
        for (int k = 0; k < 6; k++) begin
            par_bits = 4'($urandom_range(0, 15));
            settle();
            check_out("R7 direct");
        end
        par_bits = 4'hF;
        settle();
        check_out("R7 direct max");

        // R8 latched parallel
        strobe = 1'b0;
        settle();
        held = exp_word;
        par_bits = 4'h3;
        settle();
        chk("R8 hold", atten_word, held);
        pulse();
        check_out("R8 latched pulse");
        par_bits = 4'h8;
        settle();
        chk("R8 hold after pulse", atten_word, 4'h3);

        // back to serial: model unchanged by parallel-mode shift clocks (R1)
        ser_mode = 1'b1;
        settle();
        pulse();
        check_out("R1 serial after parallel");

        // random mix
        for (int it = 0; it < 60; it++) begin
            int op;
            op = int'($urandom_range(0, 4));
            case (op)
                0: send_word(8'($urandom()), 8, ser_mode && !strobe);
                1: send_word(8'($urandom()), 6, 1'b0);
                2: begin
                    if (strobe) begin
                        strobe = 1'b0;
                        settle();
                    end
                    pulse();
                end
                3: begin
                    par_bits = 4'($urandom_range(0, 15));
                    settle();
                end
                default: begin
                    ser_mode = ~ser_mode;
                    settle();
                end
            endcase
            check_out("R1 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule